// File: doc/BRIEF.md
# Load/Store Pipeline Hazard Interlock

This block decides, every cycle, whether the instruction sitting in the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) may move on. The pipeline has no result bypass paths, so a source operand can only come from the register file. The interlock compares the decode-stage source fields against the destination number and write enable carried down in the execute-stage and memory-stage pipeline registers. While any live source matches a pending write, it freezes the program counter and the fetch/decode register and pushes an empty slot into the execute stage.

The register file writes early in a cycle and reads late in the same cycle. A producer that has reached writeback therefore needs no interlock. By default the writeback-stage destination is accepted on the port but never causes a hold; a parameter can switch that comparison on for a register file without that timing. A dependent instruction waits two cycles behind an adjacent producer, one cycle behind a producer two slots ahead, and not at all behind one three or more slots ahead.

Branches test their register for non-zero in decode. A taken branch that is free to leave decode discards the instruction just fetched, which costs one cycle. A hold always beats a taken branch: the branch stays in decode and is judged again once its operand is ready.

Top module: `pipe_interlock`

## Requirements
- R1: A source that is marked as read, is non-zero, and equals the execute-stage destination while the execute-stage write enable is 1 drives `pc_hold` to 1 in the same cycle.
- R2: A source that is marked as read, is non-zero, and equals the memory-stage destination while the memory-stage write enable is 1 drives `pc_hold` to 1 in the same cycle.
- R3: A match against the writeback-stage destination alone never drives `pc_hold` to 1.
- R4: A source field equal to register 0 never causes a hold, whatever the stage destinations and enables are.
- R5: A source field whose read flag (`id_use_a` or `id_use_b`) is 0 never causes a hold.
- R6: A stage whose write enable is 0 never causes a hold, even when its destination matches a live source.
- R7: `idex_bubble` equals `pc_hold` in every cycle, so the held decode slot and the inserted empty execute slot always come together.
- R8: `if_squash` is 1 exactly when `id_br_taken` is 1 and `pc_hold` is 0.
- R9: When `pc_hold` is 1, `if_squash` is 0 even if `id_br_taken` is 1.
- R10: Running the sequence load r1; load r2; add r3=r1+r2; branch-if-r3-non-zero; load r4 via r1; load r5 via r2; sub r3=r4-r5; store r3 via r1, the instructions leave decode in cycles 0,1,4,7,8,9,12,15 when the branch is not taken. When it is taken, with the store as target, they leave in cycles 0,1,4,7 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the embedded property checks |
| rst_n | input | 1 | Active-low reset, disables the property checks |
| id_src_a | input | AW | First source register field of the decode-stage instruction |
| id_use_a | input | 1 | Decode instruction reads `id_src_a` |
| id_src_b | input | AW | Second source register field of the decode-stage instruction |
| id_use_b | input | 1 | Decode instruction reads `id_src_b` |
| id_br_taken | input | 1 | Branch in decode resolved taken |
| ex_wen | input | 1 | Register-write enable held in the execute-stage register |
| ex_dst | input | AW | Destination held in the execute-stage register |
| mem_wen | input | 1 | Register-write enable held in the memory-stage register |
| mem_dst | input | AW | Destination held in the memory-stage register |
| wb_wen | input | 1 | Register-write enable held in the writeback-stage register |
| wb_dst | input | AW | Destination held in the writeback-stage register |
| pc_hold | output | 1 | Hold the program counter and the fetch/decode register |
| idex_bubble | output | 1 | Load an empty slot with all enables cleared into the execute stage |
| if_squash | output | 1 | Replace the instruction just fetched with an empty slot |

## Verification
Random decode and stage fields are drawn from a small set of register numbers so that matches are frequent. This separates hits in execute, memory and writeback, and it exercises the read flags, register 0 and disabled write enables. Directed cases each put a single match in one stage with every other stage idle, so a wrong stage mask or a missing enable term shows up on its own. A cycle-level pipeline model in the bench then runs the eight-instruction program with the branch both taken and not taken. The decode exit cycles it records tell one-slot, two-slot and three-slot producer distances apart, and they show whether a hold correctly beats a taken branch.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  // Pipeline stages that can still hold a pending register write
  typedef enum logic [1:0] {
    WS_EX  = 2'd0,
    WS_MEM = 2'd1,
    WS_WB  = 2'd2
  } wstage_e;

  localparam int NUM_WSTAGE = 3;
  localparam int NUM_SRC    = 2;

  // Which stages must hold decode: execute and memory always,
  // writeback only if the register file cannot write-then-read.
  function automatic logic [NUM_WSTAGE-1:0] hold_mask(input bit split_phase);
    logic [NUM_WSTAGE-1:0] m;
    m = '0;
    m[WS_EX]  = 1'b1;
    m[WS_MEM] = 1'b1;
    m[WS_WB]  = !split_phase;
    return m;
  endfunction
endpackage

// File: rtl/ilk_src_match.sv
module ilk_src_match
  import ilk_pkg::*;
#(
  parameter int AW = 5,
  parameter int NW = NUM_WSTAGE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] src,
  input  logic          src_used,
  input  logic [NW-1:0] st_wen,
  input  logic [NW*AW-1:0] st_dst,
  output logic [NW-1:0] hit
);
  // A source is live only if read and not the hardwired zero register
  function automatic logic live(input logic [AW-1:0] r, input logic u);
    return u && (r != '0);
  endfunction

  function automatic logic same_reg(input logic [AW-1:0] x, input logic [AW-1:0] y);
    return x == y;
  endfunction

  logic src_live;
  assign src_live = live(src, src_used);

  for (genvar k = 0; k < NW; k++) begin : g_stage
    logic [AW-1:0] dk;
    assign dk     = st_dst[k*AW +: AW];
    assign hit[k] = src_live && st_wen[k] && same_reg(src, dk);

    // R6: a stage that will not write cannot match
    p_wen_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !st_wen[k] |-> !hit[k]);
  end

  // R4: register zero never matches
  p_zero_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (hit == '0));
  // R5: unread field never matches
  p_unused_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !src_used |-> (hit == '0));
endmodule

// File: rtl/ilk_stall_ctl.sv
module ilk_stall_ctl
  import ilk_pkg::*;
#(
  parameter int NS          = NUM_SRC,
  parameter int NW          = NUM_WSTAGE,
  parameter bit SPLIT_PHASE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NS*NW-1:0] src_hits,
  input  logic             br_taken,
  output logic             stall,
  output logic             squash
);
  localparam logic [NW-1:0] MASK = hold_mask(SPLIT_PHASE);

  logic [NS-1:0] src_blocked;

  for (genvar s = 0; s < NS; s++) begin : g_src
    assign src_blocked[s] = |(src_hits[s*NW +: NW] & MASK);
  end

  assign stall  = |src_blocked;
  assign squash = br_taken && !stall;

  // R9: a held branch never squashes fetch
  p_hold_beats_branch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !squash);
  // R8: a free taken branch squashes fetch
  p_taken_squash_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken && !stall) |-> squash);
  // R3: with split-phase writes, a writeback-only hit never holds
  if (SPLIT_PHASE) begin : g_wb_free
    logic any_early;
    always_comb begin
      any_early = 1'b0;
      for (int s = 0; s < NS; s++) begin
        any_early = any_early | src_hits[s*NW + int'(WS_EX)]
                              | src_hits[s*NW + int'(WS_MEM)];
      end
    end
    p_wb_no_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !any_early |-> !stall);
  end
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import ilk_pkg::*;
#(
  parameter int AW          = 5,
  parameter bit SPLIT_PHASE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_src_a,
  input  logic          id_use_a,
  input  logic [AW-1:0] id_src_b,
  input  logic          id_use_b,
  input  logic          id_br_taken,
  input  logic          ex_wen,
  input  logic [AW-1:0] ex_dst,
  input  logic          mem_wen,
  input  logic [AW-1:0] mem_dst,
  input  logic          wb_wen,
  input  logic [AW-1:0] wb_dst,
  output logic          pc_hold,
  output logic          idex_bubble,
  output logic          if_squash
);
  localparam int NW = NUM_WSTAGE;
  localparam int NS = NUM_SRC;

  logic [NW-1:0]    st_wen;
  logic [NW*AW-1:0] st_dst;
  logic [AW-1:0]    src   [NS];
  logic [NS-1:0]    used;
  logic [NS*NW-1:0] hits;
  logic             stall_w;
  logic             squash_w;

  assign st_wen = {wb_wen, mem_wen, ex_wen};
  assign st_dst = {wb_dst, mem_dst, ex_dst};
  assign src[0] = id_src_a;
  assign src[1] = id_src_b;
  assign used   = {id_use_b, id_use_a};

  for (genvar s = 0; s < NS; s++) begin : g_match
    ilk_src_match #(.AW(AW), .NW(NW)) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (src[s]),
      .src_used (used[s]),
      .st_wen   (st_wen),
      .st_dst   (st_dst),
      .hit      (hits[s*NW +: NW])
    );
  end

  ilk_stall_ctl #(.NS(NS), .NW(NW), .SPLIT_PHASE(SPLIT_PHASE)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_hits (hits),
    .br_taken (id_br_taken),
    .stall    (stall_w),
    .squash   (squash_w)
  );

  assign pc_hold     = stall_w;
  assign idex_bubble = stall_w;
  assign if_squash   = squash_w;

  // R1: live source matching a writing execute stage holds
  p_ex_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((id_use_a && id_src_a != '0 && ex_wen && id_src_a == ex_dst) ||
     (id_use_b && id_src_b != '0 && ex_wen && id_src_b == ex_dst)) |-> pc_hold);
  // R2: live source matching a writing memory stage holds
  p_mem_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((id_use_a && id_src_a != '0 && mem_wen && id_src_a == mem_dst) ||
     (id_use_b && id_src_b != '0 && mem_wen && id_src_b == mem_dst)) |-> pc_hold);
  // R7: hold and bubble travel together
  p_hold_bubble_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold == idex_bubble);
endmodule

// File: tb/pipe_interlock_bench.sv
module pipe_interlock_bench;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] id_src_a = '0, id_src_b = '0, ex_dst = '0, mem_dst = '0, wb_dst = '0;
  logic id_use_a = 1'b0, id_use_b = 1'b0, id_br_taken = 1'b0;
  logic ex_wen = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0;
  logic pc_hold, idex_bubble, if_squash;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pipe_interlock #(.AW(AW)) u_pipe_interlock (
    .clk(clk), .rst_n(rst_n),
    .id_src_a(id_src_a), .id_use_a(id_use_a),
    .id_src_b(id_src_b), .id_use_b(id_use_b),
    .id_br_taken(id_br_taken),
    .ex_wen(ex_wen), .ex_dst(ex_dst),
    .mem_wen(mem_wen), .mem_dst(mem_dst),
    .wb_wen(wb_wen), .wb_dst(wb_dst),
    .pc_hold(pc_hold), .idex_bubble(idex_bubble), .if_squash(if_squash)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Bench restatement of the hold rule: only execute and memory stages block
  function automatic bit src_blocks(input int r, input bit u, input bit w1, input int d1,
                                    input bit w2, input int d2);
    if (!u || r == 0) return 1'b0;
    return (w1 && d1 == r) || (w2 && d2 == r);
  endfunction

  task automatic drive(input int a, input bit ua, input int b, input bit ub, input bit br,
                       input bit ew, input int ed, input bit mw, input int md,
                       input bit ww, input int wd);
    @(negedge clk);
    id_src_a = AW'(a); id_use_a = ua; id_src_b = AW'(b); id_use_b = ub;
    id_br_taken = br; ex_wen = ew; ex_dst = AW'(ed);
    mem_wen = mw; mem_dst = AW'(md); wb_wen = ww; wb_dst = AW'(wd);
    #1;
  endtask

  // Program tables
  int  p_rs [8] = '{4, 5, 1, 3, 1, 2, 4, 1};
  int  p_rt [8] = '{1, 2, 2, 0, 4, 5, 5, 3};
  int  p_rd [8] = '{1, 2, 3, 0, 4, 5, 3, 0};
  bit  p_urt[8] = '{0, 0, 1, 0, 0, 0, 1, 1};
  bit  p_wen[8] = '{1, 1, 1, 0, 1, 1, 1, 0};
  bit  p_br [8] = '{0, 0, 0, 1, 0, 0, 0, 0};

  task automatic run_program(input bit taken);
    int leave [8];
    int exp_nt [8] = '{0, 1, 4, 7, 8, 9, 12, 15};
    int exp_tk [8] = '{0, 1, 4, 7, -1, -1, -1, 9};
    int s_ifid, s_idex, s_exmem, s_memwb, pc;
    bit st, sq;
    for (int i = 0; i < 8; i++) leave[i] = -1;
    s_ifid = 0; s_idex = -1; s_exmem = -1; s_memwb = -1; pc = 1;
    for (int c = 0; c < 24; c++) begin
      drive((s_ifid >= 0) ? p_rs[s_ifid] : 0, s_ifid >= 0,
            (s_ifid >= 0) ? p_rt[s_ifid] : 0, (s_ifid >= 0) && p_urt[s_ifid],
            (s_ifid >= 0) && p_br[s_ifid] && taken,
            (s_idex >= 0) && p_wen[s_idex], (s_idex >= 0) ? p_rd[s_idex] : 0,
            (s_exmem >= 0) && p_wen[s_exmem], (s_exmem >= 0) ? p_rd[s_exmem] : 0,
            (s_memwb >= 0) && p_wen[s_memwb], (s_memwb >= 0) ? p_rd[s_memwb] : 0);
      st = pc_hold; sq = if_squash;
      if (s_ifid >= 0 && !st) leave[s_ifid] = c;
      s_memwb = s_exmem;
      s_exmem = s_idex;
      if (st) s_idex = -1;
      else begin
        s_idex = s_ifid;
        if (sq) begin s_ifid = -1; pc = 7; end
        else begin s_ifid = (pc < 8) ? pc : -1; pc++; end
      end
    end
    for (int i = 0; i < 8; i++)
      check(taken ? "R10 taken exit cycle" : "R10 not-taken exit cycle",
            leave[i], taken ? exp_tk[i] : exp_nt[i]);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset hold", int'(pc_hold), 0);
    check("R8 reset squash", int'(if_squash), 0);
    @(negedge clk); rst_n = 1'b1;

    // Directed corners
    drive(7, 1, 0, 0, 0, 1, 7, 0, 0, 0, 0);
    check("R1 ex match a", int'(pc_hold), 1);
    drive(0, 0, 9, 1, 0, 1, 9, 0, 0, 0, 0);
    check("R1 ex match b", int'(pc_hold), 1);
    drive(7, 1, 0, 0, 0, 0, 0, 1, 7, 0, 0);
    check("R2 mem match", int'(pc_hold), 1);
    drive(7, 1, 7, 1, 0, 0, 0, 0, 0, 1, 7);
    check("R3 wb only", int'(pc_hold), 0);
    drive(0, 1, 0, 1, 0, 1, 0, 1, 0, 1, 0);
    check("R4 zero reg", int'(pc_hold), 0);
    drive(6, 0, 6, 0, 0, 1, 6, 1, 6, 0, 0);
    check("R5 unused fields", int'(pc_hold), 0);
    drive(6, 1, 6, 1, 0, 0, 6, 0, 6, 0, 0);
    check("R6 write disabled", int'(pc_hold), 0);
    drive(3, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    check("R8 free taken squash", int'(if_squash), 1);
    drive(3, 1, 0, 0, 1, 1, 3, 0, 0, 0, 0);
    check("R9 held branch squash", int'(if_squash), 0);
    check("R7 bubble with hold", int'(idex_bubble), 1);

    // Constrained random
    for (int n = 0; n < 400; n++) begin
      int a, b, ed, md, wd;
      bit ua, ub, ew, mw, ww, br, es;
      a = $urandom % 4; b = $urandom % 4; ed = $urandom % 4; md = $urandom % 4;
      wd = $urandom % 4;
      ua = 1'($urandom); ub = 1'($urandom); ew = 1'($urandom); mw = 1'($urandom);
      ww = 1'($urandom); br = 1'($urandom);
      drive(a, ua, b, ub, br, ew, ed, mw, md, ww, wd);
      es = src_blocks(a, ua, ew, ed, mw, md) || src_blocks(b, ub, ew, ed, mw, md);
      check("R1 R2 R3 R4 R5 R6 random hold", int'(pc_hold), int'(es));
      check("R7 random bubble", int'(idex_bubble), int'(es));
      check("R8 R9 random squash", int'(if_squash), int'(br && !es));
    end

    run_program(1'b0);
    run_program(1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule